// File: doc/BRIEF.md
# Low-Power Operating Mode Sequencer

This block sequences the operating mode of a bus-transceiver supervisory device. A control word written by the host carries two mode bits, a not-standby bit and a transmit-enable bit. The block applies them on each write strobe, selecting active transmit, listen-only, battery stand-by with the regulator kept on, or sleep with the regulator off. A watchdog failure pulls the active modes back into stand-by. A wake event in sleep does the same. In both low-power modes a wake sets a latched flag, and that flag drives the receive-data line low so the host sees why it woke.

Wake pins are filtered for duration in the fast clock domain. A level change in either direction counts only once it has held for a set number of clocks. A cyclic sense timer, advanced by a slow time-base tick, pulses the high-side switch enable in the low-power modes. Sleep entry with cyclic sense on compares two pulse-time samples of the wake pins, and if they disagree the block falls back to stand-by and raises an initialisation-fail flag.

Top module: `lp_mode_ctrl`

## Requirements
- R1: The mode output equals {not-standby, transmit-enable}: 2'b11 active, 2'b10 listen-only, 2'b00 stand-by, 2'b01 sleep. reg_en is low only in sleep, tx_en is high only in 2'b11, and rx_en is high in 2'b11 and 2'b10. Reset gives stand-by with all flags clear.
- R2: The mode changes only on a cycle with cfg_load high, or through a watchdog or wake event. Writes made while in sleep are ignored.
- R3: wdg_rst in active or listen-only mode moves the mode to stand-by on the next clock, even if a write arrives in the same cycle. In stand-by or sleep it leaves the mode unchanged.
- R4: A wake event in sleep (bus_wake, or a filtered pin event) moves the mode to stand-by on the next clock and sets the wake flag.
- R5: A wake event in stand-by sets the wake flag, and rxd_wake_n is low while the flag is set. Wake events in active or listen-only mode do not set the flag.
- R6: A wake pin event is a level change in either direction that stays unchanged for WAKE_MIN_CYC consecutive clocks. A change lasting fewer clocks has no effect.
- R7: A write with cfg_wkclr high clears the wake flag. While cfg_wkclr is high, no wake event can set the flag.
- R8: A write moving from stand-by to active or listen-only clears the wake flag and the initialisation-fail flag.
- R9: A sleep request made in stand-by while the wake flag is set is refused, and the mode stays stand-by.
- R10: With cfg_cs_en high in sleep or stand-by, hs_en is high for one tick interval out of every CS_PERIOD ticks, starting at phase zero. In the active modes hs_en is low.
- R11: On sleep entry with cfg_cs_en high, the wake pins are sampled at two consecutive hs_en pulses. If the samples differ, the mode returns to stand-by and init_fail is set. If they match, sleep is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base tick |
| cfg_load | input | 1 | Control word write strobe |
| cfg_nstb | input | 1 | Not-standby mode bit |
| cfg_ent | input | 1 | Transmit-enable mode bit |
| cfg_wkclr | input | 1 | Wake flag clear bit (level) |
| cfg_cs_en | input | 1 | Cyclic sense enable (level) |
| wdg_rst | input | 1 | Watchdog reset pulse |
| bus_wake | input | 1 | Wake pulse from the bus receiver |
| wk_pin | input | N_WAKE | Wake input pins |
| mode | output | 2 | Current operating mode |
| reg_en | output | 1 | Regulator enable |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| hs_en | output | 1 | High-side switch enable |
| rxd_wake_n | output | 1 | Receive-data wake indication, active low |
| wake_flag | output | 1 | Latched wake flag |
| init_fail | output | 1 | Sleep-entry sample mismatch flag |

## Verification
The bench builds the block with WAKE_MIN_CYC = 4 and CS_PERIOD = 8. These values bring the exact clock where the duration filter accepts or rejects a pin change within a few cycles. They also let the bench cover a full cyclic-sense period and the two-sample sleep-entry check with ten or so hand-driven ticks. The bench places a sub-threshold pin glitch exactly on the second sample strobe, so the mismatch path is exercised without the duration filter also reporting a wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_STBY   = 2'b00,
        MODE_SLEEP  = 2'b01,
        MODE_LISTEN = 2'b10,
        MODE_ACTIVE = 2'b11
    } mode_e;

    function automatic logic is_low_power(mode_e m);
        return (m == MODE_STBY) || (m == MODE_SLEEP);
    endfunction

    function automatic logic is_active(mode_e m);
        return (m == MODE_ACTIVE) || (m == MODE_LISTEN);
    endfunction

endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter #(
    parameter int MIN_CYC  = 32,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic evt
);
    localparam int CW = $clog2(MIN_CYC + 1);

    typedef struct packed {
        logic          ref_lvl;
        logic [CW-1:0] cnt;
        logic          evt;
    } filt_s;

    filt_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (pin != s_q.ref_lvl) begin
            if (s_q.cnt == CW'(MIN_CYC - 1)) begin
                s_d.ref_lvl = pin;
                s_d.cnt     = '0;
                s_d.evt     = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ref_lvl: IDLE_LVL, cnt: '0, evt: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign evt = s_q.evt;

endmodule

// File: rtl/lpm_cyc_timer.sv
module lpm_cyc_timer #(
    parameter int PERIOD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic pulse,
    output logic sample_stb
);
    localparam int PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == PW'(PERIOD - 1)) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse      = en && (cnt_q == '0);
    assign sample_stb = pulse && tick;

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int N_WAKE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  mode_e             req_mode,
    input  logic              cfg_wkclr,
    input  logic              cfg_cs_en,
    input  logic              wdg_rst,
    input  logic              wake_evt,
    input  logic              sample_stb,
    input  logic [N_WAKE-1:0] wk_lvl,
    output mode_e             mode,
    output logic              wake_flag,
    output logic              init_fail
);
    localparam logic [1:0] INIT_FIRST  = 2'd0;
    localparam logic [1:0] INIT_SECOND = 2'd1;
    localparam logic [1:0] INIT_DONE   = 2'd2;

    typedef struct packed {
        mode_e             mode;
        logic              wake_flag;
        logic              init_fail;
        logic [1:0]        init_cnt;
        logic [N_WAKE-1:0] ref_lvl;
    } fsm_s;

    fsm_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            MODE_ACTIVE, MODE_LISTEN: begin
                if (wdg_rst) begin
                    s_d.mode = MODE_STBY;
                end else if (cfg_load) begin
                    s_d.mode = req_mode;
                    if (req_mode == MODE_SLEEP) begin
                        s_d.init_cnt = cfg_cs_en ? INIT_FIRST : INIT_DONE;
                    end
                end
            end
            MODE_STBY: begin
                if (!wdg_rst && cfg_load) begin
                    if (is_active(req_mode)) begin
                        s_d.mode      = req_mode;
                        s_d.wake_flag = 1'b0;
                        s_d.init_fail = 1'b0;
                    end else if (req_mode == MODE_SLEEP &&
                                 !s_q.wake_flag && !wake_evt) begin
                        s_d.mode     = MODE_SLEEP;
                        s_d.init_cnt = cfg_cs_en ? INIT_FIRST : INIT_DONE;
                    end
                end
            end
            MODE_SLEEP: begin
                if (wake_evt) begin
                    s_d.mode = MODE_STBY;
                end else if (sample_stb && s_q.init_cnt != INIT_DONE) begin
                    if (s_q.init_cnt == INIT_FIRST) begin
                        s_d.ref_lvl  = wk_lvl;
                        s_d.init_cnt = INIT_SECOND;
                    end else if (wk_lvl != s_q.ref_lvl) begin
                        s_d.mode      = MODE_STBY;
                        s_d.init_fail = 1'b1;
                        s_d.init_cnt  = INIT_DONE;
                    end else begin
                        s_d.init_cnt = INIT_DONE;
                    end
                end
            end
            default: s_d.mode = MODE_STBY;
        endcase

        if (cfg_wkclr) begin
            if (cfg_load) begin
                s_d.wake_flag = 1'b0;
            end
        end else if (wake_evt && s_d.mode == MODE_STBY) begin
            s_d.wake_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_STBY, wake_flag: 1'b0, init_fail: 1'b0,
                     init_cnt: INIT_DONE, ref_lvl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode      = s_q.mode;
    assign wake_flag = s_q.wake_flag;
    assign init_fail = s_q.init_fail;

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
    import lpm_pkg::*;
#(
    parameter int N_WAKE       = 2,
    parameter int WAKE_MIN_CYC = 32,
    parameter int CS_PERIOD    = 128,
    parameter bit WAKE_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_load,
    input  logic              cfg_nstb,
    input  logic              cfg_ent,
    input  logic              cfg_wkclr,
    input  logic              cfg_cs_en,
    input  logic              wdg_rst,
    input  logic              bus_wake,
    input  logic [N_WAKE-1:0] wk_pin,
    output logic [1:0]        mode,
    output logic              reg_en,
    output logic              tx_en,
    output logic              rx_en,
    output logic              hs_en,
    output logic              rxd_wake_n,
    output logic              wake_flag,
    output logic              init_fail
);
    logic [N_WAKE-1:0] pin_evt;
    logic              wake_any;
    logic              cs_en_eff;
    logic              cs_pulse;
    logic              cs_sample;
    mode_e             cur_mode;
    mode_e             req_mode;

    for (genvar i = 0; i < N_WAKE; i++) begin : g_wk
        lpm_wake_filter #(
            .MIN_CYC  (WAKE_MIN_CYC),
            .IDLE_LVL (WAKE_IDLE)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (wk_pin[i]),
            .evt   (pin_evt[i])
        );
    end

    assign wake_any  = bus_wake || (|pin_evt);
    assign req_mode  = mode_e'({cfg_nstb, cfg_ent});
    assign cs_en_eff = cfg_cs_en && is_low_power(cur_mode);

    lpm_cyc_timer #(
        .PERIOD (CS_PERIOD)
    ) u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cs_en_eff),
        .tick       (tick),
        .pulse      (cs_pulse),
        .sample_stb (cs_sample)
    );

    lpm_mode_fsm #(
        .N_WAKE (N_WAKE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .req_mode   (req_mode),
        .cfg_wkclr  (cfg_wkclr),
        .cfg_cs_en  (cfg_cs_en),
        .wdg_rst    (wdg_rst),
        .wake_evt   (wake_any),
        .sample_stb (cs_sample),
        .wk_lvl     (wk_pin),
        .mode       (cur_mode),
        .wake_flag  (wake_flag),
        .init_fail  (init_fail)
    );

    assign mode       = cur_mode;
    assign reg_en     = (cur_mode != MODE_SLEEP);
    assign tx_en      = (cur_mode == MODE_ACTIVE);
    assign rx_en      = is_active(cur_mode);
    assign hs_en      = cs_pulse;
    assign rxd_wake_n = ~wake_flag;

endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cfg_load,
    input logic       cfg_wkclr,
    input logic       wdg_rst,
    input logic       bus_wake,
    input logic [1:0] mode,
    input logic       hs_en,
    input logic       wake_flag
);
    p_wdg_to_stby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && wdg_rst) |=> (mode == 2'b00));

    p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !cfg_load && !wdg_rst) |=> $stable(mode));

    p_sleep_no_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> !mode[1]);

    p_bus_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && bus_wake && !cfg_wkclr) |=> (mode == 2'b00 && wake_flag));

    p_refuse_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && wake_flag) |=> (mode != 2'b01));

    p_clr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wkclr && !wake_flag) |=> !wake_flag);

    p_flag_in_stby_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag |-> (mode == 2'b00));

    p_hs_one_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && tick) |=> !hs_en);

endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg_load  (cfg_load),
    .cfg_wkclr (cfg_wkclr),
    .wdg_rst   (wdg_rst),
    .bus_wake  (bus_wake),
    .mode      (mode),
    .hs_en     (hs_en),
    .wake_flag (wake_flag)
);

// File: tb/tb_lp_mode_ctrl.sv
module tb_lp_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MINC       = 4;
    localparam int PER        = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cfg_load = 1'b0, cfg_nstb = 1'b0, cfg_ent = 1'b0;
    logic cfg_wkclr = 1'b0, cfg_cs_en = 1'b0, wdg_rst = 1'b0, bus_wake = 1'b0;
    logic [1:0] wk_pin = 2'b11;
    logic [1:0] mode;
    logic reg_en, tx_en, rx_en, hs_en, rxd_wake_n, wake_flag, init_fail;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lp_mode_ctrl #(.N_WAKE(2), .WAKE_MIN_CYC(MINC), .CS_PERIOD(PER)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_load(cfg_load),
        .cfg_nstb(cfg_nstb), .cfg_ent(cfg_ent), .cfg_wkclr(cfg_wkclr),
        .cfg_cs_en(cfg_cs_en), .wdg_rst(wdg_rst), .bus_wake(bus_wake),
        .wk_pin(wk_pin), .mode(mode), .reg_en(reg_en), .tx_en(tx_en),
        .rx_en(rx_en), .hs_en(hs_en), .rxd_wake_n(rxd_wake_n),
        .wake_flag(wake_flag), .init_fail(init_fail)
    );

    // {load, nstb, ent, wdg, expected mode[1:0]}
    localparam int NV = 11;
    localparam logic [5:0] VEC [NV] = '{
        6'b1110_11, 6'b1100_10, 6'b0010_10, 6'b0001_00, 6'b0001_00,
        6'b1110_11, 6'b1101_00, 6'b1100_10, 6'b1010_01, 6'b1110_01,
        6'b0001_01
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic nstb, logic ent, logic clr);
        cfg_nstb = nstb; cfg_ent = ent; cfg_wkclr = clr; cfg_load = 1'b1;
        cyc(1);
        cfg_load = 1'b0;
    endtask

    task automatic do_tick(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
        end
    endtask

    task automatic pulse_bus;
        bus_wake = 1'b1;
        cyc(1);
        bus_wake = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL WDOG: run did not finish, actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 reset mode", 8'(mode), 8'h0);
        chk("R1 reset reg_en", 8'(reg_en), 8'h1);
        chk("R1 reset tx/rx", 8'({tx_en, rx_en}), 8'h0);
        chk("R5 reset flag/rxd", 8'({wake_flag, rxd_wake_n}), 8'h1);
        chk("R10 reset hs_en", 8'(hs_en), 8'h0);

        // R1 R2 R3 vector walk
        for (int v = 0; v < NV; v++) begin
            cfg_load = VEC[v][5]; cfg_nstb = VEC[v][4];
            cfg_ent = VEC[v][3]; wdg_rst = VEC[v][2];
            cyc(1);
            cfg_load = 1'b0; wdg_rst = 1'b0;
            chk("R1/R2/R3 vector mode", 8'(mode), 8'(VEC[v][1:0]));
            chk("R1 vector enables", 8'({reg_en, tx_en, rx_en}),
                8'({VEC[v][1:0] != 2'b01, VEC[v][1:0] == 2'b11, VEC[v][1]}));
        end

        // R4 bus wake in sleep
        pulse_bus();
        chk("R4 sleep wake mode", 8'(mode), 8'h0);
        chk("R5 wake flag rxd low", 8'({wake_flag, rxd_wake_n}), 8'h2);

        // R9 sleep refused with flag set
        write(1'b0, 1'b1, 1'b0);
        chk("R9 refused sleep", 8'(mode), 8'h0);

        // R7 clear and blocking
        write(1'b0, 1'b0, 1'b1);
        chk("R7 flag cleared", 8'({wake_flag, rxd_wake_n}), 8'h1);
        pulse_bus();
        cyc(1);
        chk("R7 blocked while clr high", 8'(wake_flag), 8'h0);
        write(1'b0, 1'b0, 1'b0);

        // R6 short glitch ignored, long edge accepted (falling)
        wk_pin[0] = 1'b0;
        cyc(MINC - 1);
        wk_pin[0] = 1'b1;
        cyc(6);
        chk("R6 short glitch ignored", 8'(wake_flag), 8'h0);
        wk_pin[0] = 1'b0;
        cyc(MINC);
        chk("R6 not before threshold", 8'(wake_flag), 8'h0);
        cyc(1);
        chk("R6 falling edge wake", 8'(wake_flag), 8'h1);

        // R8 stby -> active clears flag
        write(1'b1, 1'b1, 1'b0);
        chk("R8 active mode", 8'(mode), 8'h3);
        chk("R8 flag cleared", 8'(wake_flag), 8'h0);
        wk_pin[0] = 1'b1;
        cyc(MINC + 2);
        pulse_bus();
        cyc(1);
        chk("R5 no flag in active", 8'({mode, wake_flag}), 8'h6);

        // R10 cyclic sense pulse
        cfg_cs_en = 1'b1;
        cyc(1);
        chk("R10 hs low in active", 8'(hs_en), 8'h0);
        wdg_rst = 1'b1;
        cyc(1);
        wdg_rst = 1'b0;
        chk("R3 wdg to stby", 8'(mode), 8'h0);
        chk("R10 hs phase zero", 8'(hs_en), 8'h1);
        do_tick(1);
        chk("R10 hs one tick", 8'(hs_en), 8'h0);
        do_tick(PER - 2);
        chk("R10 hs still low", 8'(hs_en), 8'h0);
        do_tick(1);
        chk("R10 hs period", 8'(hs_en), 8'h1);

        // R11 sample mismatch on sleep entry
        write(1'b0, 1'b1, 1'b0);
        chk("R11 sleep entered", 8'(mode), 8'h1);
        do_tick(PER);
        chk("R11 sleep during init", 8'(mode), 8'h1);
        wk_pin[1] = 1'b0;
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
        wk_pin[1] = 1'b1;
        chk("R11 mismatch to stby", 8'({mode, init_fail}), 8'h1);
        cyc(MINC + 2);
        chk("R11 no wake flag", 8'(wake_flag), 8'h0);

        // R8 init_fail clear, R11 matching samples
        write(1'b1, 1'b0, 1'b0);
        chk("R8 init_fail cleared", 8'({mode, init_fail}), 8'h4);
        write(1'b0, 1'b1, 1'b0);
        do_tick(PER + 1);
        chk("R11 match keeps sleep", 8'({mode, init_fail}), 8'h2);

        // R4 pin wake (rising side restored later) from sleep
        wk_pin[1] = 1'b0;
        cyc(MINC + 1);
        chk("R4 pin wake mode", 8'(mode), 8'h0);
        chk("R5 pin wake rxd", 8'({wake_flag, rxd_wake_n}), 8'h2);
        write(1'b0, 1'b0, 1'b1);
        write(1'b0, 1'b0, 1'b0);
        wk_pin[1] = 1'b1;
        cyc(MINC + 1);
        chk("R6 rising edge wake", 8'(wake_flag), 8'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule